// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit with Early Termination

This block computes the low 32 bits of a product of two operands and can add a third operand to it. A single-cycle start pulse carries the multiplicand, the multiplier, the addend, an accumulate select and a set-flags select. The unit then retires the multiplier two bits per clock using a radix-4 recoding in which each digit overlaps the one below it. It stops as soon as the multiplier bits it has not yet consumed are all zero, so a small multiplier finishes in few cycles and a large one takes up to sixteen.

The low half of a product is the same whether the operands are read as signed or as unsigned, so the unit has no signedness input. When the result is ready, `done` pulses for one clock and `result` holds that value until the next completion. If set-flags was selected, a flag-write strobe comes with `done`. The negative and zero flags then describe the result, the carry output is a fixed zero, and the overflow output passes the caller's current overflow value through unchanged.

Top module: `iter_mac`

## Requirements
- R1: Without accumulate, `result` equals the low 32 bits of op_m*op_s.
- R2: With `acc_sel`=1, `result` equals the low 32 bits of op_m*op_s + op_n.
- R3: The result does not depend on any signedness reading: op_m=0xFFFFFFF6 with op_s=0x00000014 gives 0xFFFFFF38.
- R4: If `start` is sampled high at clock edge E while the unit is idle, `done` is high in the cycle after edge E+m. Here m is the smallest value from 1 to 16 with op_s < 2^(2m-1), and m is 16 when no value qualifies.
- R5: op_s equal to 0 or to 1 completes with m=1.
- R6: Any op_s with bit 31 set takes m=16, and no operation takes more than 16 internal cycles.
- R7: `done` is high for exactly one clock per accepted operation, and `result` keeps its value after `done` until the next completion.
- R8: A `start` sampled while an operation is in progress is ignored. The ongoing result is unchanged and no extra `done` follows.
- R9: With `set_flags`=1, `flag_we` is high in the `done` cycle, `flag_n` equals result bit 31, and `flag_z` is 1 exactly when the result is zero.
- R10: With `set_flags`=0, `flag_we` stays 0 for the whole operation, including its `done` cycle.
- R11: `flag_c` is always 0 and `flag_v` always equals `flag_v_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse; sampled only when idle |
| op_m | input | 32 | Multiplicand |
| op_s | input | 32 | Multiplier; its magnitude sets the cycle count |
| op_n | input | 32 | Addend used in accumulate mode |
| acc_sel | input | 1 | 1 selects multiply-accumulate |
| set_flags | input | 1 | 1 requests a flag write at completion |
| flag_v_in | input | 1 | Caller's current overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the result, held after done |
| flag_we | output | 1 | Flag write enable, valid with done |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, fixed 0 |
| flag_v | output | 1 | Overflow flag, passed through |

## Verification
Multipliers that sit on either side of each early-stop threshold (2^(2m-1)-1 against 2^(2m-1)), together with a walking single bit, show whether the cycle count follows the magnitude rule and whether the overlapping digit is handled at every position. Operands with bit 31 set, all ones and the negative example check the negative recoded digits and the 16-cycle cap. They also show that the low half is the same for signed and unsigned readings. Accumulate and plain runs with the same operands tell the initial accumulator value apart. Zero and negative results with set-flags on and off, a second start sent during a long run, and a toggling overflow input cover the flag rules and the rule that a start sent while busy is ignored.

// File: rtl/iter_mac_pkg.sv
package iter_mac_pkg;

  typedef enum logic [2:0] {
    DG_ZERO = 3'd0,
    DG_POS1 = 3'd1,
    DG_POS2 = 3'd2,
    DG_NEG1 = 3'd3,
    DG_NEG2 = 3'd4
  } digit_e;

  // Radix-4 overlapped recoding of {b(2k+1), b(2k), b(2k-1)}
  function automatic digit_e decode_digit(input logic [2:0] trio);
    case (trio)
      3'b001, 3'b010: decode_digit = DG_POS1;
      3'b011:         decode_digit = DG_POS2;
      3'b100:         decode_digit = DG_NEG2;
      3'b101, 3'b110: decode_digit = DG_NEG1;
      default:        decode_digit = DG_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/iter_mac_seq.sv
module iter_mac_seq
  import iter_mac_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_s,
  output logic             busy,
  output logic             accept,
  output logic             step_fire,
  output logic             last_step,
  output digit_e           digit,
  output logic             done
);
  localparam int unsigned MAX_STEPS = WIDTH / 2;
  localparam int unsigned IDX_W     = $clog2(MAX_STEPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_STEPS - 1);

  logic [WIDTH:0]     mplier;
  logic [WIDTH:0]     mpl_shift;
  logic [IDX_W-1:0]   step_idx;
  logic               rest_zero;
  logic               cap_hit;

  assign accept    = start & ~busy;
  assign step_fire = busy;
  assign mpl_shift = mplier >> 2;
  assign rest_zero = (mpl_shift == '0);
  assign cap_hit   = (step_idx == LAST_IDX);
  assign last_step = busy & (rest_zero | cap_hit);
  assign digit     = decode_digit(mplier[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier   <= '0;
      step_idx <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        mplier   <= {op_s, 1'b0};
        step_idx <= '0;
        busy     <= 1'b1;
      end else if (step_fire) begin
        mplier   <= mpl_shift;
        step_idx <= step_idx + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iter_mac_dp.sv
module iter_mac_dp
  import iter_mac_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             step_fire,
  input  logic             last_step,
  input  digit_e           digit,
  input  logic [WIDTH-1:0] op_m,
  input  logic [WIDTH-1:0] op_n,
  input  logic             acc_sel,
  output logic [WIDTH-1:0] sum_next,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] addend;

  function automatic logic [WIDTH-1:0] partial_term(
    input logic [WIDTH-1:0] m, input digit_e d);
    case (d)
      DG_POS1: partial_term = m;
      DG_POS2: partial_term = m << 1;
      DG_NEG1: partial_term = ~m + 1'b1;
      DG_NEG2: partial_term = ~(m << 1) + 1'b1;
      default: partial_term = '0;
    endcase
  endfunction

  assign addend   = partial_term(mcand, digit);
  assign sum_next = acc + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      result <= '0;
    end else if (accept) begin
      acc   <= acc_sel ? op_n : '0;
      mcand <= op_m;
    end else if (step_fire) begin
      acc   <= sum_next;
      mcand <= mcand << 2;
      if (last_step) result <= sum_next;
    end
  end

endmodule

// File: rtl/iter_mac_flags.sv
module iter_mac_flags #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             set_flags,
  input  logic             last_step,
  input  logic [WIDTH-1:0] sum_next,
  input  logic             flag_v_in,
  output logic             flag_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  logic sf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q    <= 1'b0;
      flag_we <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
    end else begin
      if (accept) sf_q <= set_flags;
      flag_we <= last_step & sf_q;
      if (last_step && sf_q) begin
        flag_n <= sum_next[WIDTH-1];
        flag_z <= (sum_next == '0);
      end
    end
  end

  assign flag_c = 1'b0;
  assign flag_v = flag_v_in;

endmodule

// File: rtl/iter_mac.sv
module iter_mac
  import iter_mac_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_m,
  input  logic [WIDTH-1:0] op_s,
  input  logic [WIDTH-1:0] op_n,
  input  logic             acc_sel,
  input  logic             set_flags,
  input  logic             flag_v_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             flag_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  logic             accept;
  logic             step_fire;
  logic             last_step;
  digit_e           digit;
  logic [WIDTH-1:0] sum_next;

  iter_mac_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_s(op_s),
    .busy(busy), .accept(accept), .step_fire(step_fire),
    .last_step(last_step), .digit(digit), .done(done)
  );

  iter_mac_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_fire(step_fire),
    .last_step(last_step), .digit(digit), .op_m(op_m), .op_n(op_n),
    .acc_sel(acc_sel), .sum_next(sum_next), .result(result)
  );

  iter_mac_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .accept(accept), .set_flags(set_flags),
    .last_step(last_step), .sum_next(sum_next), .flag_v_in(flag_v_in),
    .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

endmodule

// File: rtl/iter_mac_chk.sv
module iter_mac_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             accept,
  input logic             last_step,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic             flag_we,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v,
  input logic             flag_v_in
);
  localparam int unsigned MAX_STEPS = WIDTH / 2;
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (accept) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
  end

  // R6
  step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < MAX_STEPS));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !last_step) |=> (busy && !done));

  // R9
  flag_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (done && flag_n == result[WIDTH-1] && flag_z == (result == '0)));

  // R10
  flag_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !flag_we);

  // R11
  flag_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_c == 1'b0) && (flag_v == flag_v_in));

endmodule

bind iter_mac iter_mac_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .accept(accept),
  .last_step(last_step), .done(done), .result(result), .flag_we(flag_we),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
  .flag_v_in(flag_v_in)
);

// File: tb/iter_mac_bench.sv
module iter_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_m = '0, op_s = '0, op_n = '0;
  logic        acc_sel = 1'b0, set_flags = 1'b0, flag_v_in = 1'b0;
  logic        busy, done, flag_we, flag_n, flag_z, flag_c, flag_v;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] res;
    int          lat;
    logic        sf;
    int          t0;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] last_res = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iter_mac u_iter_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .op_m(op_m), .op_s(op_s),
    .op_n(op_n), .acc_sel(acc_sel), .set_flags(set_flags),
    .flag_v_in(flag_v_in), .busy(busy), .done(done), .result(result),
    .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic int want_cycles(input logic [31:0] s);
    for (int m = 1; m <= 16; m++)
      if ({32'd0, s} < (64'd1 << (2*m - 1))) return m;
    return 16;
  endfunction

  // Monitor: pops expected items and compares at each completion
  always @(negedge clk) begin
    if (rst_n) begin
      chk(flag_c == 1'b0 && flag_v == flag_v_in, "R11 c/v", {flag_c, flag_v}, {1'b0, flag_v_in});
      if (!done) chk(!flag_we, "R10 we without done", flag_we, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R8 unexpected done", result, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(result == e.res, {e.tag, " result"}, result, e.res);
          chk(cyc - e.t0 - 1 == e.lat, "R4 latency", cyc - e.t0 - 1, e.lat);
          chk(flag_we == e.sf, e.sf ? "R9 we" : "R10 we", flag_we, e.sf);
          if (e.sf) begin
            chk(flag_n == e.res[31], "R9 N", flag_n, e.res[31]);
            chk(flag_z == (e.res == 0), "R9 Z", flag_z, e.res == 0);
          end
          last_res = e.res;
        end
      end
    end
  end

  task automatic issue(input logic [31:0] m, input logic [31:0] s,
                       input logic [31:0] n, input logic acc,
                       input logic sf, input string tag);
    exp_t e;
    @(negedge clk);
    e.res = m * s + (acc ? n : 32'd0);
    e.lat = want_cycles(s);
    e.sf  = sf;
    e.t0  = cyc;
    e.tag = tag;
    sb.push_back(e);
    op_m = m; op_s = s; op_n = n; acc_sel = acc; set_flags = sf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    flag_v_in = ~flag_v_in;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(result == last_res, "R7 hold", result, last_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !flag_we && result == 0, "reset", {busy, done, flag_we}, 0);
    rst_n = 1'b1;

    issue(32'hFFFF_FFF6, 32'h14, 0, 0, 1, "R3 example");
    issue(32'h1234_5678, 32'h0, 0, 0, 1, "R5 rs0");
    issue(32'h1234_5678, 32'h1, 0, 0, 1, "R5 rs1");
    issue(32'h0BAD_F00D, 32'h2, 32'h11, 0, 0, "R1 rs2");
    issue(32'h0BAD_F00D, 32'h7, 0, 0, 1, "R1 rs7");
    issue(32'h0BAD_F00D, 32'h8, 0, 0, 1, "R1 rs8");
    issue(32'hDEAD_BEEF, 32'h8000_0000, 0, 0, 1, "R6 bit31");
    issue(32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 0, 1, "R6 ones");
    issue(32'hDEAD_BEEF, 32'h7FFF_FFFF, 0, 0, 0, "R1 max positive");
    issue(32'hCAFE_0001, 32'h0000_1234, 32'h1000_0000, 1, 1, "R2 acc");
    issue(32'hCAFE_0001, 32'h0000_1234, 32'h1000_0000, 0, 1, "R1 same no acc");
    issue(32'h0, 32'h55, 32'h0, 1, 1, "R9 zero");
    issue(32'h1, 32'h1, 32'hFFFF_FFFF, 1, 1, "R9 wrap zero");
    issue(32'h0, 32'h9, 32'h8000_0000, 1, 1, "R9 negative");
    issue(32'h0, 32'h9, 32'h8000_0000, 1, 0, "R10 no flags");
    for (int i = 1; i < 16; i++) begin
      issue(32'h9E37_79B9, (32'd1 << (2*i - 1)) - 1, 32'h5, 1, 1, "R4 below");
      issue(32'h9E37_79B9, 32'd1 << (2*i - 1), 32'h5, 1, 1, "R4 at");
    end
    for (int i = 0; i < 32; i++)
      issue(32'h8765_4321 ^ i, 32'd1 << i, 32'h0, 0, 1, "R1 walk");

    // R8: second start during a 16-cycle run is ignored
    begin
      exp_t e;
      @(negedge clk);
      e.res = 32'h0000_0003 * 32'hF000_0000;
      e.lat = 16; e.sf = 1'b1; e.t0 = cyc; e.tag = "R8 first op";
      sb.push_back(e);
      op_m = 32'h3; op_s = 32'hF000_0000; op_n = 0; acc_sel = 0; set_flags = 1; start = 1;
      @(negedge clk);
      start = 0;
      repeat (3) @(negedge clk);
      op_m = 32'h7777; op_s = 32'h1; op_n = 32'h99; acc_sel = 1; set_flags = 0; start = 1;
      @(negedge clk);
      start = 0;
      chk(busy, "R8 still busy", busy, 1);
      while (sb.size() != 0) @(negedge clk);
      repeat (25) @(negedge clk);
      chk(result == 32'h3 * 32'hF000_0000, "R8 result kept", result, 32'h3 * 32'hF000_0000);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule